// File: doc/BRIEF.md
# Host Memory Window Translator

This block places a movable window of the host address space over a larger video memory. A host access that lands inside the window becomes a memory request. Its device address is the distance from the window start, plus an origin offset, plus a page offset. That sum wraps within the video memory. Accesses outside the window produce no memory request. A read outside the window returns all ones.

The 32-bit data passing through can be reordered by three independent swap stages: bit reversal inside each byte, a byte exchange inside each 16-bit half, and an exchange of the two halves. Writes and reads use the same transform, so data written and read back under one setting comes back unchanged.

A small configuration port sets the window start, the size code, the origin, the page offset and the swap selection. Accesses are taken one per cycle. The memory side is registered. Read responses come from a second registered stage.

Top module: `hmw_xlate`

## Requirements
- R1: Bit 0 of the format register (config offset 5, bits 2:0) reverses the bit order inside every byte of the data.
- R2: Bit 1 of the format register exchanges the two bytes of each 16-bit half of the data.
- R3: Bit 2 of the format register exchanges the upper and lower 16-bit halves. Enabled stages apply in the order bit reversal, then byte exchange, then half exchange. The same transform is used for write data (host to memory) and for read data (memory to host).
- R4: A word written and then read back with the same format setting returns unchanged.
- R5: The size code (config offset 1, bits 3:0) selects a window of 4096 << code bytes. A host address hits when base <= address < base + size, where the base is config offset 0.
- R6: A size code above 13 is stored as 13, which gives a 32 MiB window.
- R7: The device address is (address - base) + origin + page, taken modulo 2^VA_W. The page register is config offset 4.
- R8: Config offsets 2 and 3 both write the same origin register. The most recent write through either offset sets the origin.
- R9: An access that misses raises no memory request. A read that misses returns 32'hFFFFFFFF.
- R10: m_req, m_write, m_addr and m_wdata reflect an access one clock edge after it is presented. h_rvalid and h_rdata for a read come two edges after it, and a write produces no h_rvalid.
- R11: After reset, m_req and h_rvalid are low and all configuration registers are zero. That gives a 4 KiB window at address 0 with no swapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| h_valid | input | 1 | Host access valid |
| h_write | input | 1 | Host access is a write |
| h_addr | input | AW | Host byte address |
| h_wdata | input | 32 | Host write data |
| m_rdata | input | 32 | Memory read data for the current m_addr, same cycle |
| m_req | output | 1 | Memory request |
| m_write | output | 1 | Memory request is a write |
| m_addr | output | VA_W | Device memory byte address |
| m_wdata | output | 32 | Swapped write data to memory |
| h_rvalid | output | 1 | Host read response valid |
| h_rdata | output | 32 | Swapped read data, or all ones on a miss |

## Verification
The memory-side outputs of an access are due one rising edge after the access is presented. The bench captures them at the falling edge that follows. Read responses are due one edge later, and the bench captures them at the next falling edge. A configuration write therefore finishes at least one full cycle before the access that depends on it. Each scenario task drives its inputs at a falling edge and samples at these two fixed points. No check depends on ordering at a rising edge.

// File: rtl/hmw_pkg.sv
// Package: shared constants and types for the host memory window translator.
// Assumes a 32-bit data path; swap stages are defined for that width only.
package hmw_pkg;
    localparam int DW            = 32;
    localparam int BASE_SHIFT    = 12;   // code 0 window = 4 KiB
    localparam logic [3:0] SIZE_CODE_MAX = 4'hD;

    // Configuration register offsets
    typedef enum logic [2:0] {
        CFG_BASE    = 3'd0,
        CFG_SIZE    = 3'd1,
        CFG_ORG     = 3'd2,
        CFG_ORG_ALT = 3'd3,
        CFG_PAGE    = 3'd4,
        CFG_FMT     = 3'd5
    } cfg_off_e;

    // Data format selection, one bit per swap stage
    typedef struct packed {
        logic half_sw;   // bit 2
        logic byte_sw;   // bit 1
        logic bit_rev;   // bit 0
    } fmt_t;
endpackage

// File: rtl/hmw_regs.sv
// Module: configuration registers for the window (base, size, origin, page, format).
// Assumes one write per cycle; the origin is writable at two offsets and the
// size code is clamped on write so stored values never exceed the maximum.
module hmw_regs
    import hmw_pkg::*;
#(
    parameter int AW   = 32,
    parameter int VA_W = 23
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_addr,
    input  logic [DW-1:0]   cfg_wdata,
    output logic [AW-1:0]   base_q,
    output logic [3:0]      size_q,
    output logic [VA_W-1:0] org_q,
    output logic [VA_W-1:0] page_q,
    output fmt_t            fmt_q
);
    logic [3:0] size_in;

    // Clamp the incoming size code to the largest supported window
    always_comb size_in = (cfg_wdata[3:0] > SIZE_CODE_MAX) ? SIZE_CODE_MAX : cfg_wdata[3:0];

    // Register writes decoded by offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
            org_q  <= '0;
            page_q <= '0;
            fmt_q  <= '0;
        end else if (cfg_we) begin
            case (cfg_off_e'(cfg_addr))
                CFG_BASE:              base_q <= cfg_wdata[AW-1:0];
                CFG_SIZE:              size_q <= size_in;
                CFG_ORG, CFG_ORG_ALT:  org_q  <= cfg_wdata[VA_W-1:0];
                CFG_PAGE:              page_q <= cfg_wdata[VA_W-1:0];
                CFG_FMT:               fmt_q  <= fmt_t'(cfg_wdata[2:0]);
                default: ;
            endcase
        end
    end

    p_size_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 3'd1 && cfg_wdata[3:0] > SIZE_CODE_MAX) |=> (size_q == SIZE_CODE_MAX));

    p_origin_alias_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 3'd3) |=> (org_q == $past(cfg_wdata[VA_W-1:0])));
endmodule

// File: rtl/hmw_decode.sv
// Module: window hit decode and device address generation (combinational).
// Assumes VA_W <= AW and a size code no larger than the package maximum.
module hmw_decode
    import hmw_pkg::*;
#(
    parameter int AW   = 32,
    parameter int VA_W = 23
) (
    input  logic [AW-1:0]   addr,
    input  logic [AW-1:0]   base,
    input  logic [3:0]      size_code,
    input  logic [VA_W-1:0] org,
    input  logic [VA_W-1:0] page,
    output logic            hit,
    output logic [VA_W-1:0] dev_addr
);
    logic [AW:0]   diff;
    logic [5:0]    sh;
    logic [AW-1:0] lim;

    // Offset from base with borrow, and the window limit mask from the size code
    always_comb begin
        diff = {1'b0, addr} - {1'b0, base};
        sh   = 6'(BASE_SHIFT) + {2'b00, size_code};
        lim  = (AW'(1) << sh) - AW'(1);
    end

    // Hit when no borrow and no offset bit above the window limit
    always_comb hit = ~diff[AW] & ~|(diff[AW-1:0] & ~lim);

    // Device address: window offset plus origin plus page, wrapping in VA_W bits
    always_comb dev_addr = diff[VA_W-1:0] + org + page;
endmodule

// File: rtl/hmw_swap.sv
// Module: three-stage data reorder (bit reverse per byte, byte swap per half,
// half swap). Each stage is its own inverse and the stages commute, so the
// whole transform is its own inverse.
module hmw_swap
    import hmw_pkg::*;
(
    input  fmt_t          fmt,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int NBYTE = DW / 8;
    localparam int NHALF = DW / 16;

    logic [DW-1:0] rev, bsw, rev_s, bsw_s;

    // Stage 1 wiring: bit order reversed inside each byte
    for (genvar gb = 0; gb < NBYTE; gb++) begin : g_byte
        for (genvar gi = 0; gi < 8; gi++) begin : g_bit
            assign rev[8*gb + gi] = din[8*gb + 7 - gi];
        end
    end

    // Stage 1 select
    always_comb rev_s = fmt.bit_rev ? rev : din;

    // Stage 2 wiring: bytes exchanged inside each 16-bit half
    for (genvar gh = 0; gh < NHALF; gh++) begin : g_half
        assign bsw[16*gh +: 8]     = rev_s[16*gh + 8 +: 8];
        assign bsw[16*gh + 8 +: 8] = rev_s[16*gh +: 8];
    end

    // Stage 2 select
    always_comb bsw_s = fmt.byte_sw ? bsw : rev_s;

    // Stage 3: halves exchanged
    always_comb dout = fmt.half_sw ? {bsw_s[15:0], bsw_s[31:16]} : bsw_s;
endmodule

// File: rtl/hmw_xlate.sv
// Module: host memory window translator top. Decodes window hits, forms the
// device address, swaps data both ways, and registers the memory request
// (one edge) and the read response (second edge).
// Assumes the memory presents m_rdata for m_addr in the same cycle as m_req.
module hmw_xlate
    import hmw_pkg::*;
#(
    parameter int AW   = 32,
    parameter int VA_W = 23
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_addr,
    input  logic [31:0]     cfg_wdata,
    input  logic            h_valid,
    input  logic            h_write,
    input  logic [AW-1:0]   h_addr,
    input  logic [31:0]     h_wdata,
    input  logic [31:0]     m_rdata,
    output logic            m_req,
    output logic            m_write,
    output logic [VA_W-1:0] m_addr,
    output logic [31:0]     m_wdata,
    output logic            h_rvalid,
    output logic [31:0]     h_rdata
);
    logic [AW-1:0]   base_q;
    logic [3:0]      size_q;
    logic [VA_W-1:0] org_q, page_q, dev_addr;
    fmt_t            fmt_q, fmt_pl;
    logic            hit, miss_rd_q;
    logic [31:0]     wr_sw, rd_sw;

    hmw_regs #(.AW(AW), .VA_W(VA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .base_q(base_q), .size_q(size_q),
        .org_q(org_q), .page_q(page_q), .fmt_q(fmt_q)
    );

    hmw_decode #(.AW(AW), .VA_W(VA_W)) u_dec (
        .addr(h_addr), .base(base_q), .size_code(size_q), .org(org_q),
        .page(page_q), .hit(hit), .dev_addr(dev_addr)
    );

    hmw_swap u_wsw (.fmt(fmt_q),  .din(h_wdata), .dout(wr_sw));
    hmw_swap u_rsw (.fmt(fmt_pl), .din(m_rdata), .dout(rd_sw));

    // Request stage: register the translated access toward memory
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_req     <= 1'b0;
            m_write   <= 1'b0;
            m_addr    <= '0;
            m_wdata   <= '0;
            miss_rd_q <= 1'b0;
            fmt_pl    <= '0;
        end else begin
            m_req     <= h_valid & hit;
            m_write   <= h_write;
            m_addr    <= dev_addr;
            m_wdata   <= wr_sw;
            miss_rd_q <= h_valid & ~hit & ~h_write;
            fmt_pl    <= fmt_q;
        end
    end

    // Response stage: register read data back to the host
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_rvalid <= 1'b0;
            h_rdata  <= '0;
        end else begin
            h_rvalid <= (m_req & ~m_write) | miss_rd_q;
            h_rdata  <= miss_rd_q ? '1 : rd_sw;
        end
    end

    p_miss_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (h_valid && !hit) |=> !m_req);

    p_miss_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rvalid && $past(miss_rd_q)) |-> (h_rdata == 32'hFFFF_FFFF));

    p_req_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> $past(h_valid));

    p_rvalid_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        h_rvalid |-> ($past(m_req && !m_write) || $past(miss_rd_q)));
endmodule

// File: tb/sim_hmw_xlate.sv
`timescale 1ns/1ps
module sim_hmw_xlate;
    localparam int AW   = 32;
    localparam int VA_W = 23;
    localparam logic [31:0] WBASE = 32'h4000_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [2:0]      cfg_addr = '0;
    logic [31:0]     cfg_wdata = '0;
    logic            h_valid = 1'b0, h_write = 1'b0;
    logic [AW-1:0]   h_addr = '0;
    logic [31:0]     h_wdata = '0;
    logic [31:0]     m_rdata;
    logic            m_req, m_write, h_rvalid;
    logic [VA_W-1:0] m_addr;
    logic [31:0]     m_wdata, h_rdata;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    logic            s_req, s_rv;
    logic [VA_W-1:0] s_addr;
    logic [31:0]     s_wdata, s_rd;

    logic [31:0] mem [256];

    always #4 clk = ~clk;

    hmw_xlate #(.AW(AW), .VA_W(VA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .h_valid(h_valid), .h_write(h_write),
        .h_addr(h_addr), .h_wdata(h_wdata), .m_rdata(m_rdata),
        .m_req(m_req), .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
        .h_rvalid(h_rvalid), .h_rdata(h_rdata)
    );

    // Zero-wait memory model
    assign m_rdata = mem[m_addr[9:2]];
    always @(posedge clk) if (m_req && m_write) mem[m_addr[9:2]] <= m_wdata;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [2:0] off, input logic [31:0] val);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = off; cfg_wdata = val;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); h_valid = 1'b1; h_write = wr; h_addr = a; h_wdata = d;
        @(negedge clk); s_req = m_req; s_addr = m_addr; s_wdata = m_wdata; h_valid = 1'b0;
        @(negedge clk); s_rv = h_rvalid; s_rd = h_rdata;
    endtask

    task automatic t_reset;
        chk("R11 m_req after reset", {31'b0, m_req}, 32'd0);
        chk("R11 h_rvalid after reset", {31'b0, h_rvalid}, 32'd0);
        access(1'b1, 32'h0000_0FFC, 32'h1);
        chk("R11 default window hit", {31'b0, s_req}, 32'd1);
        chk("R11 default addr", {9'b0, s_addr}, 32'h0FFC);
        access(1'b1, 32'h0000_1000, 32'h1);
        chk("R11 default window end", {31'b0, s_req}, 32'd0);
    endtask

    task automatic t_window;
        cfg(3'd0, WBASE); cfg(3'd1, 32'd2); cfg(3'd2, 32'h100); cfg(3'd4, 32'h2000);
        access(1'b1, WBASE + 32'h10, 32'h5);
        chk("R10 req one edge later", {31'b0, s_req}, 32'd1);
        chk("R7 device address", {9'b0, s_addr}, 32'h2110);
        chk("R10 no rvalid on write", {31'b0, s_rv}, 32'd0);
        access(1'b1, WBASE + 32'h3FFC, 32'h5);
        chk("R5 last byte hit", {31'b0, s_req}, 32'd1);
        access(1'b1, WBASE + 32'h4000, 32'h5);
        chk("R5 R9 past end miss", {31'b0, s_req}, 32'd0);
        access(1'b1, WBASE - 32'h4, 32'h5);
        chk("R5 R9 below base miss", {31'b0, s_req}, 32'd0);
    endtask

    task automatic t_alias;
        cfg(3'd3, 32'h300);
        access(1'b1, WBASE + 32'h10, 32'h5);
        chk("R8 origin via second offset", {9'b0, s_addr}, 32'h2310);
        cfg(3'd2, 32'h40);
        access(1'b1, WBASE + 32'h10, 32'h5);
        chk("R8 origin via first offset", {9'b0, s_addr}, 32'h2050);
    endtask

    task automatic t_wrap;
        cfg(3'd2, 32'h7F_FFF0); cfg(3'd4, 32'h20);
        access(1'b1, WBASE + 32'h10, 32'h5);
        chk("R7 wrap modulo video memory", {9'b0, s_addr}, 32'h20);
    endtask

    task automatic t_clamp;
        cfg(3'd2, 32'h0); cfg(3'd4, 32'h0); cfg(3'd1, 32'hF);
        access(1'b1, WBASE + 32'h01FF_FFFC, 32'h5);
        chk("R6 clamped window last word", {31'b0, s_req}, 32'd1);
        access(1'b1, WBASE + 32'h0200_0000, 32'h5);
        chk("R6 clamped window end", {31'b0, s_req}, 32'd0);
        cfg(3'd1, 32'd2);
    endtask

    task automatic t_swap;
        cfg(3'd5, 32'd1); access(1'b1, WBASE + 32'h10, 32'h1234_5678);
        chk("R1 bit reverse", s_wdata, 32'h482C_6A1E);
        cfg(3'd5, 32'd2); access(1'b1, WBASE + 32'h10, 32'h1234_5678);
        chk("R2 byte swap", s_wdata, 32'h3412_7856);
        cfg(3'd5, 32'd4); access(1'b1, WBASE + 32'h10, 32'h1234_5678);
        chk("R3 half swap", s_wdata, 32'h5678_1234);
        cfg(3'd5, 32'd7); access(1'b1, WBASE + 32'h10, 32'h1234_5678);
        chk("R3 all stages", s_wdata, 32'h1E6A_2C48);
        cfg(3'd5, 32'd3); access(1'b1, WBASE + 32'h10, 32'h1234_5678);
        chk("R1 R2 combined", s_wdata, 32'h2C48_1E6A);
    endtask

    task automatic t_roundtrip;
        cfg(3'd5, 32'd7);
        access(1'b1, WBASE + 32'h20, 32'hCAFE_F00D);
        access(1'b0, WBASE + 32'h20, 32'h0);
        chk("R10 read rvalid two edges later", {31'b0, s_rv}, 32'd1);
        chk("R4 round trip", s_rd, 32'hCAFE_F00D);
        cfg(3'd5, 32'd0);
        access(1'b1, WBASE + 32'h30, 32'h1234_5678);
        cfg(3'd5, 32'd4);
        access(1'b0, WBASE + 32'h30, 32'h0);
        chk("R3 read path swap", s_rd, 32'h5678_1234);
        cfg(3'd5, 32'd0);
    endtask

    task automatic t_readmiss;
        access(1'b0, WBASE + 32'h0010_0000, 32'h0);
        chk("R9 read miss no req", {31'b0, s_req}, 32'd0);
        chk("R9 read miss rvalid", {31'b0, s_rv}, 32'd1);
        chk("R9 read miss data", s_rd, 32'hFFFF_FFFF);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_window();
        t_alias();
        t_wrap();
        t_clamp();
        t_swap();
        t_roundtrip();
        t_readmiss();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule